// File: doc/BRIEF.md
# DMX512 Packet Transmitter

This block sends a whole lighting-control packet on one serial line. A packet opens with a long low break. A short high mark-after-break follows. Then comes a first slot that carries a zero start code. After it come a fixed number of channel slots, all carrying one byte. That byte is captured from the channel-value input when the start strobe is accepted.

Every slot is framed the same way: one low start bit, eight data bits sent least-significant first, and two high stop bits. Bit timing comes from an internal clock divider. The divider counts only while slots are on the line. The break and the mark-after-break are timed by a separate gap counter in the sequencer.

The host raises a one-cycle start strobe while the block is idle. It then watches the busy flag, or waits for the one-cycle done pulse. The line driver, any receive path and any per-channel storage sit outside this block. At elaboration, a configuration with a break shorter than 22 bit times, a mark-after-break shorter than 2 bit times, or a channel count outside 1 to 512 is rejected.

Top module: `dmx_packet_tx`

## Requirements
- R1: After reset and whenever no packet is in progress, the line is high, busy is low and done is low.
- R2: In the cycle after a start strobe is accepted, the line goes low and stays low for exactly BREAK_BITS × CLKS_PER_BIT clock cycles.
- R3: The break is followed by a high mark-after-break lasting exactly MAB_BITS × CLKS_PER_BIT cycles.
- R4: Every slot lasts 11 bit times of CLKS_PER_BIT cycles each. Bit 0 is low, bits 1 to 8 carry data bits 0 to 7 (least-significant first), and bits 9 and 10 are high. Slots follow one another with no gap, and the bit divider counts only while slots are being sent.
- R5: The first slot after the mark-after-break carries the value 0x00.
- R6: Exactly NUM_CHANNELS channel slots follow the start code, and each one carries the same byte.
- R7: The channel byte is the value of chan_value_i in the cycle the start strobe is accepted. Changes to chan_value_i later in the packet have no effect on the line.
- R8: A start strobe that arrives while busy is high is ignored: the packet and its timing go on unchanged.
- R9: Busy is high from the cycle after the strobe is accepted until the final stop bit ends.
- R10: Done is high for exactly one cycle: the cycle right after the final stop bit ends, which is also the first cycle with busy low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while idle |
| chan_value_i | input | 8 | Byte sent in every channel slot |
| line_o | output | 1 | Serial output line, high at mark |
| busy_o | output | 1 | A packet is in progress |
| done_o | output | 1 | One-cycle pulse when a packet ends |

## Verification
Two events can fall in the same cycle. One is a new start strobe arriving while a packet is running. The other is the end of a slot, where the serializer both reloads its frame and takes a bit tick from the divider. The bench raises the strobe, with a different channel value, once during the break and once in the middle of a slot. It then compares every cycle of the line against a waveform rebuilt from the requirements, so the strobe must leave the timing and the data untouched. The packets are short, so the boundaries between slots are crossed many times. Any lost or doubled bit at a reload shows up as a shifted frame, and the check for the final done pulse falls on the wrong cycle.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;

    localparam int SLOT_BITS  = 11;
    localparam int DATA_BITS  = 8;
    localparam logic [DATA_BITS-1:0] START_CODE = '0;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BREAK = 2'd1,
        PH_MAB   = 2'd2,
        PH_SLOTS = 2'd3
    } dmx_phase_e;

endpackage

// File: rtl/dmx_bit_divider.sv
module dmx_bit_divider #(
    parameter int CLKS_PER_BIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int DIV_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = '0;
        tick_o = 1'b0;
        if (run_i) begin
            if (cnt_q == DIV_LAST) begin
                tick_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the divider stays cleared whenever slots are not being sent
    assert_div_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

    // R4: a tick is followed by a full bit period before the next one
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/dmx_slot_serializer.sv
module dmx_slot_serializer
    import dmx_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [DATA_BITS-1:0] byte_i,
    input  logic                 tick_i,
    output logic                 bit_o,
    output logic                 last_o
);
    localparam int IDX_W = $clog2(SLOT_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic [SLOT_BITS-1:0] frame;
        logic [IDX_W-1:0]     idx;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        last_o = tick_i && (s_q.idx == IDX_LAST);
        if (load_i) begin
            // stop bits high on top, start bit low at the bottom
            s_d.frame = {2'b11, byte_i, 1'b0};
            s_d.idx   = '0;
        end else if (tick_i) begin
            s_d.frame = {1'b1, s_q.frame[SLOT_BITS-1:1]};
            s_d.idx   = (s_q.idx == IDX_LAST) ? s_q.idx : s_q.idx + 1'b1;
        end
    end

    assign bit_o = s_q.frame[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.frame <= '1;
            s_q.idx   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4: a freshly loaded slot opens with a low start bit
    assert_start_bit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (bit_o == 1'b0));

    // R4: the slot end only comes when the two stop bits are on the line
    assert_stop_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (bit_o == 1'b1));

endmodule

// File: rtl/dmx_packet_tx.sv
module dmx_packet_tx
    import dmx_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 64,
    parameter int BREAK_BITS   = 22,
    parameter int MAB_BITS     = 2,
    parameter int NUM_CHANNELS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] chan_value_i,
    output logic       line_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int BREAK_CLKS = BREAK_BITS * CLKS_PER_BIT;
    localparam int MAB_CLKS   = MAB_BITS * CLKS_PER_BIT;
    localparam int GAP_MAX    = (BREAK_CLKS > MAB_CLKS) ? BREAK_CLKS : MAB_CLKS;
    localparam int GAP_W      = $clog2(GAP_MAX + 1);
    localparam int SLOT_W     = $clog2(NUM_CHANNELS + 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_CHANNELS);

    generate
        if (BREAK_BITS < 22 || MAB_BITS < 2 || NUM_CHANNELS < 1 ||
            NUM_CHANNELS > 512 || CLKS_PER_BIT < 2) begin : g_cfg_reject
            $error("dmx_packet_tx: timing or channel count below the allowed range");
        end
    endgenerate

    typedef struct packed {
        dmx_phase_e          phase;
        logic [GAP_W-1:0]    gap;
        logic [SLOT_W-1:0]   slot;
        logic [DATA_BITS-1:0] value;
        logic                done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                 div_run;
    logic                 bit_tick;
    logic                 ser_load;
    logic [DATA_BITS-1:0] ser_byte;
    logic                 ser_bit;
    logic                 slot_end;

    assign div_run = (seq_q.phase == PH_SLOTS);

    dmx_bit_divider #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_divider (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (div_run),
        .tick_o (bit_tick)
    );

    dmx_slot_serializer u_serializer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ser_load),
        .byte_i (ser_byte),
        .tick_i (bit_tick),
        .bit_o  (ser_bit),
        .last_o (slot_end)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ser_load   = 1'b0;
        ser_byte   = START_CODE;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_BREAK;
                    seq_d.gap   = GAP_W'(BREAK_CLKS - 1);
                    seq_d.slot  = '0;
                    seq_d.value = chan_value_i;
                end
            end
            PH_BREAK: begin
                if (seq_q.gap == '0) begin
                    seq_d.phase = PH_MAB;
                    seq_d.gap   = GAP_W'(MAB_CLKS - 1);
                end else begin
                    seq_d.gap = seq_q.gap - 1'b1;
                end
            end
            PH_MAB: begin
                if (seq_q.gap == '0) begin
                    seq_d.phase = PH_SLOTS;
                    seq_d.slot  = '0;
                    ser_load    = 1'b1;
                    ser_byte    = START_CODE;
                end else begin
                    seq_d.gap = seq_q.gap - 1'b1;
                end
            end
            PH_SLOTS: begin
                if (slot_end) begin
                    if (seq_q.slot == SLOT_LAST) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.slot = seq_q.slot + 1'b1;
                        ser_load   = 1'b1;
                        ser_byte   = seq_q.value;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.gap   <= '0;
            seq_q.slot  <= '0;
            seq_q.value <= '0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        unique case (seq_q.phase)
            PH_BREAK: line_o = 1'b0;
            PH_SLOTS: line_o = ser_bit;
            default:  line_o = 1'b1;
        endcase
    end

    assign busy_o = (seq_q.phase != PH_IDLE);
    assign done_o = seq_q.done;

    // R1: the line rests at mark whenever no packet is running
    assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> line_o);

    // R2: the break holds the line low
    assert_break_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_BREAK) |-> !line_o);

    // R4: the bit divider only runs during slots
    assert_tick_in_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (seq_q.phase == PH_SLOTS));

    // R7: the captured byte cannot change during a packet
    assert_value_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(seq_q.value)));

    // R8: a strobe during a packet does not restart the break
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && seq_q.phase != PH_BREAK) |=> (seq_q.phase != PH_BREAK));

    // R10: done is a single-cycle pulse at the end of busy
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/test_dmx_packet_tx.sv
module test_dmx_packet_tx;

    localparam int CPB   = 4;
    localparam int BRK   = 22;
    localparam int MAB   = 2;
    localparam int NCH   = 3;
    localparam int B_CLK = BRK * CPB;
    localparam int M_CLK = MAB * CPB;
    localparam int S_CLK = 11 * CPB;
    localparam int TOTAL = B_CLK + M_CLK + (NCH + 1) * S_CLK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] chan_value_i = 8'h00;
    logic       line_o, busy_o, done_o;

    int n_checks = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dmx_packet_tx #(
        .CLKS_PER_BIT(CPB),
        .BREAK_BITS  (BRK),
        .MAB_BITS    (MAB),
        .NUM_CHANNELS(NCH)
    ) i_dmx_packet_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .chan_value_i(chan_value_i),
        .line_o      (line_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected line level k cycles after the accepting edge
    function automatic logic exp_line(input int k, input logic [7:0] v);
        int r, s, b;
        logic [7:0] byt;
        if (k < B_CLK) return 1'b0;
        if (k < B_CLK + M_CLK) return 1'b1;
        if (k >= TOTAL) return 1'b1;
        r = k - B_CLK - M_CLK;
        s = r / S_CLK;
        b = (r % S_CLK) / CPB;
        byt = (s == 0) ? 8'h00 : v;
        if (b == 0) return 1'b0;
        if (b <= 8) return byt[b-1];
        return 1'b1;
    endfunction

    // runs one packet; with disturb set, strobes again and alters the value mid-packet
    task automatic run_packet(input logic [7:0] val, input bit disturb, input string name);
        int e_brk = 0, e_mab = 0, e_frm = 0, e_sc = 0, e_ch = 0;
        int e_busy = 0, e_done = 0, e_idle = 0;
        @(negedge clk);
        start_i = 1'b1;
        chan_value_i = val;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= TOTAL + 6; k++) begin
            logic el;
            int r, b, s;
            el = exp_line(k, val);
            r = k - B_CLK - M_CLK;
            s = (r >= 0) ? r / S_CLK : 0;
            b = (r >= 0) ? (r % S_CLK) / CPB : 0;
            if (line_o !== el) begin
                if (k < B_CLK) e_brk++;
                else if (k < B_CLK + M_CLK) e_mab++;
                else if (k >= TOTAL) e_idle++;
                else if (b == 0 || b > 8) e_frm++;
                else if (s == 0) e_sc++;
                else e_ch++;
            end
            if (busy_o !== (k < TOTAL)) begin
                if (k >= TOTAL) e_idle++;
                else e_busy++;
            end
            if (done_o !== (k == TOTAL)) e_done++;
            if (disturb) begin
                if (k == 10 || k == B_CLK + M_CLK + S_CLK + 6) begin
                    start_i = 1'b1;
                    chan_value_i = val ^ 8'h5A;
                end else begin
                    start_i = 1'b0;
                end
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        $display("packet %s value=%02h", name, val);
        check(e_brk == 0, "R2 break length", e_brk, 0);
        check(e_mab == 0, "R3 mark-after-break", e_mab, 0);
        check(e_frm == 0, "R4 slot framing", e_frm, 0);
        check(e_sc == 0, "R5 start code", e_sc, 0);
        check(e_ch == 0, disturb ? "R7 captured value" : "R6 channel slots", e_ch, 0);
        check(e_busy == 0, disturb ? "R8 strobe while busy" : "R9 busy span", e_busy, 0);
        check(e_done == 0, "R10 done pulse", e_done, 0);
        check(e_idle == 0, "R1 idle after packet", e_idle, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(line_o === 1'b1, "R1 reset line", line_o, 1);
        check(busy_o === 1'b0, "R1 reset busy", busy_o, 0);
        check(done_o === 1'b0, "R1 reset done", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        test_reset();
        run_packet(8'h3A, 1'b0, "lsb-first");
        run_packet(8'h01, 1'b0, "single-bit");
        run_packet(8'hFF, 1'b0, "all-ones");
        run_packet(8'h6C, 1'b1, "disturbed");
        run_packet(8'h00, 1'b0, "all-zero");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule